// File: doc/BRIEF.md
# Two-Level Lookahead Adder

This block adds two 16-bit unsigned operands and a carry input in pure combinational logic. The datapath is split into four 4-bit slices. Each slice forms per-bit carry generate (both operand bits set) and carry propagate (operand bits differ) signals. It expands every internal carry into a flat sum of products over those signals and the slice's own carry input. Each slice also exports a slice-wide propagate and generate pair.

A second lookahead stage takes the four slice pairs and the block carry input. It produces the carry into each upper slice and the final carry out directly, using the same flattened equations. No carry passes from one slice to the next. The block also exports a block-wide propagate and generate pair, so that a wider adder can stack another level of lookahead on top of it.

Top module: `cla_adder16`

## Requirements
- R1: `sum` equals the low 16 bits of opA + opB + carryIn, for every input combination.
- R2: `carryOut` equals bit 16 of opA + opB + carryIn.
- R3: `grpProp` is 1 exactly when opA XOR opB is 16'hFFFF, that is, when every bit position has exactly one operand bit set.
- R4: `grpGen` is 1 exactly when opA + opB, with no carry input, is 2^16 or more.
- R5: `grpProp` and `grpGen` are never 1 together.
- R6: `carryOut` equals grpGen OR (grpProp AND carryIn).
- R7: An incoming carry crosses every slice boundary. For opA=16'hFFFF, opB=0 and carryIn=1 the outputs are sum=0, carryOut=1 and grpProp=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 16 | First operand |
| opB | input | 16 | Second operand |
| carryIn | input | 1 | Carry into bit 0 |
| sum | output | 16 | Sum bits |
| carryOut | output | 1 | Carry out of bit 15 |
| grpProp | output | 1 | Block-wide carry propagate |
| grpGen | output | 1 | Block-wide carry generate |

## Verification
The bench builds the block with its default values: four slices of four bits each. With these values every slice carry and every second-level carry is a distinct product term. The bench drives random operands, and operand pairs chosen to make a carry propagate through a whole slice or through the whole block. These pairs include all ones plus a carry, alternating bit patterns, and carries generated at the top bit of a slice. Together they exercise every term of the flattened carry equations at both levels.

// File: rtl/cla_pkg.sv
package cla_pkg;
  parameter int GROUP_W_DEF    = 4;
  parameter int NUM_GROUPS_DEF = 4;
endpackage

// File: rtl/cla_lookahead.sv
// Flattened two-level carry lookahead over N propagate/generate pairs.
module cla_lookahead #(
  parameter int N = 4
) (
  input  logic [N-1:0] pIn,
  input  logic [N-1:0] gIn,
  input  logic         cIn,
  output logic [N:0]   carry,
  output logic         blkProp,
  output logic         blkGen
);
  always_comb begin
    carry[0] = cIn;
    for (int k = 1; k <= N; k++) begin
      logic acc;
      logic chain;
      chain = cIn;
      for (int j = 0; j < k; j++) chain = chain & pIn[j];
      acc = chain;
      for (int j = 0; j < k; j++) begin
        logic term;
        term = gIn[j];
        for (int m = j + 1; m < k; m++) term = term & pIn[m];
        acc = acc | term;
      end
      carry[k] = acc;
    end
  end

  always_comb begin
    logic gAcc;
    gAcc = 1'b0;
    for (int j = 0; j < N; j++) begin
      logic term;
      term = gIn[j];
      for (int m = j + 1; m < N; m++) term = term & pIn[m];
      gAcc = gAcc | term;
    end
    blkGen  = gAcc;
    blkProp = &pIn;
  end
endmodule

// File: rtl/cla_group.sv
// One slice: bitwise propagate/generate, local lookahead, sum bits.
module cla_group #(
  parameter int GW = 4
) (
  input  logic [GW-1:0] aIn,
  input  logic [GW-1:0] bIn,
  input  logic          cIn,
  output logic [GW-1:0] sOut,
  output logic          grpP,
  output logic          grpG
);
  logic [GW-1:0] pBit, gBit;
  logic [GW:0]   cLocal;

  assign pBit = aIn ^ bIn;
  assign gBit = aIn & bIn;

  cla_lookahead #(.N(GW)) u_la (
    .pIn(pBit), .gIn(gBit), .cIn(cIn),
    .carry(cLocal), .blkProp(grpP), .blkGen(grpG)
  );

  assign sOut = pBit ^ cLocal[GW-1:0];

  always_comb begin
    if (!$isunknown({aIn, bIn, cIn})) begin
      // R1
      slice_sum_chk: assert ({cLocal[GW], sOut} ==
        ({1'b0, aIn} + {1'b0, bIn} + {{GW{1'b0}}, cIn}))
        else $error("slice sum mismatch");
      // R5
      slice_pg_excl_chk: assert (!(grpP && grpG))
        else $error("slice P and G both high");
    end
  end
endmodule

// File: rtl/cla_adder16.sv
module cla_adder16 #(
  parameter int GROUP_W    = cla_pkg::GROUP_W_DEF,
  parameter int NUM_GROUPS = cla_pkg::NUM_GROUPS_DEF,
  localparam int WIDTH     = GROUP_W * NUM_GROUPS
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sum,
  output logic             carryOut,
  output logic             grpProp,
  output logic             grpGen
);
  logic [NUM_GROUPS-1:0] sliceP, sliceG;
  logic [NUM_GROUPS:0]   sliceCarry;

  cla_lookahead #(.N(NUM_GROUPS)) u_top_la (
    .pIn(sliceP), .gIn(sliceG), .cIn(carryIn),
    .carry(sliceCarry), .blkProp(grpProp), .blkGen(grpGen)
  );

  for (genvar gi = 0; gi < NUM_GROUPS; gi++) begin : g_slice
    cla_group #(.GW(GROUP_W)) u_grp (
      .aIn (opA[gi*GROUP_W +: GROUP_W]),
      .bIn (opB[gi*GROUP_W +: GROUP_W]),
      .cIn (sliceCarry[gi]),
      .sOut(sum[gi*GROUP_W +: GROUP_W]),
      .grpP(sliceP[gi]),
      .grpG(sliceG[gi])
    );
  end

  assign carryOut = sliceCarry[NUM_GROUPS];

  always_comb begin
    if (!$isunknown({opA, opB, carryIn})) begin
      // R2
      block_sum_chk: assert ({carryOut, sum} ==
        ({1'b0, opA} + {1'b0, opB} + {{WIDTH{1'b0}}, carryIn}))
        else $error("block sum mismatch");
      // R6
      carry_out_pg_chk: assert (carryOut == (grpGen | (grpProp & carryIn)))
        else $error("carry out disagrees with block P/G");
      // R5
      block_pg_excl_chk: assert (!(grpProp && grpGen))
        else $error("block P and G both high");
      // R3
      block_prop_chk: assert (grpProp == ((opA ^ opB) == {WIDTH{1'b1}}))
        else $error("block propagate wrong");
    end
  end
endmodule

// File: tb/cla_adder16_tb.sv
module cla_adder16_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [15:0] opA, opB, sum;
  logic carryIn, carryOut, grpProp, grpGen;
  int nVec = 0;
  int nBad = 0;
  bit done = 0;

  cla_adder16 u_dut (
    .opA(opA), .opB(opB), .carryIn(carryIn),
    .sum(sum), .carryOut(carryOut), .grpProp(grpProp), .grpGen(grpGen)
  );

  task automatic applyVec(input logic [15:0] a, input logic [15:0] b, input logic c);
    int full, noC;
    logic expP, expG;
    @(negedge clk);
    opA = a; opB = b; carryIn = c;
    @(posedge clk); #1;
    full = int'(a) + int'(b) + int'(c);
    noC  = int'(a) + int'(b);
    expP = ((a ^ b) == 16'hFFFF);
    expG = (noC >= 65536);
    nVec++;
    if (sum !== full[15:0]) begin
      nBad++; $display("FAIL R1 sum a=%h b=%h c=%0b: got %h exp %h", a, b, c, sum, full[15:0]);
    end
    if (carryOut !== full[16]) begin
      nBad++; $display("FAIL R2 carryOut a=%h b=%h c=%0b: got %0b exp %0b", a, b, c, carryOut, full[16]);
    end
    if (grpProp !== expP) begin
      nBad++; $display("FAIL R3 grpProp a=%h b=%h: got %0b exp %0b", a, b, grpProp, expP);
    end
    if (grpGen !== expG) begin
      nBad++; $display("FAIL R4 grpGen a=%h b=%h: got %0b exp %0b", a, b, grpGen, expG);
    end
    if (grpProp && grpGen) begin
      nBad++; $display("FAIL R5 both P and G high: got 11 exp not 11");
    end
    if (carryOut !== (expG | (expP & c))) begin
      nBad++; $display("FAIL R6 carryOut vs P/G: got %0b exp %0b", carryOut, expG | (expP & c));
    end
  endtask

  initial begin
    opA = '0; opB = '0; carryIn = 1'b0;
    applyVec(16'h0000, 16'h0000, 1'b0);       // idle state: all zero
    // R7: carry ripples through every slice boundary
    applyVec(16'hFFFF, 16'h0000, 1'b1);
    if (sum !== 16'h0000 || carryOut !== 1'b1 || grpProp !== 1'b1) begin
      nBad++; $display("FAIL R7 got sum=%h co=%0b p=%0b exp 0000 1 1", sum, carryOut, grpProp);
    end
    applyVec(16'hFFFF, 16'h0001, 1'b0);
    applyVec(16'hFFFF, 16'hFFFF, 1'b1);
    applyVec(16'hAAAA, 16'h5555, 1'b0);
    applyVec(16'hAAAA, 16'h5555, 1'b1);
    applyVec(16'h5555, 16'h5555, 1'b1);
    applyVec(16'hAAAA, 16'hAAAA, 1'b0);
    applyVec(16'h8000, 16'h8000, 1'b0);
    applyVec(16'h0FFF, 16'h0001, 1'b0);
    applyVec(16'h00FF, 16'h0000, 1'b1);
    applyVec(16'h0008, 16'h0008, 1'b0);       // generate at slice top bit
    applyVec(16'h0888, 16'h0888, 1'b1);
    applyVec(16'hF0F0, 16'h0F0F, 1'b1);
    for (int i = 0; i < 3000; i++)
      applyVec(16'($urandom), 16'($urandom), 1'($urandom));
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      nBad++;
      $display("FAIL watchdog expired: got hang exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end
endmodule